// File: doc/BRIEF.md
# Instruction Fetch Block Buffer

This block keeps a handful of recently fetched instruction-cache blocks between a fetch stage and the instruction memory port. Every entry is tagged with an address-space ID and a block-aligned address, and a lookup matches only when both agree. Requests for blocks that are already being fetched are merged into a separate list of outstanding misses, so each block is read from memory at most once while it is in flight.

A fetch is split in two steps. An initiate step either joins an outstanding miss, takes a reference on a buffered block, or issues a full-block memory read. A complete step returns the instruction word. The response to an initiate (`req_from_buf_o`) tells the requester which kind of completion to send later: a buffered completion or a miss completion. Each entry counts the instructions still waiting on it. An entry with waiters is never replaced. The ready buffer is kept in recency order: index 0 is the least recently used entry, and the highest occupied index is the most recently used one.

Fill data and squashes may arrive in the same cycle as a request. Within one cycle the fill is applied first, then the request, then the squash.

Top module: `fetch_blk_buf`

## Requirements
- R1: After reset both lists are empty: any completion stalls (`req_ack_o`=0), and any initiate is treated as a miss that raises `mem_rd_valid_o`.
- R2: A lookup matches only when both the address-space ID and the block-aligned address (`pc` with its low log2(BLK_BYTES) bits cleared) are equal. A block held under one ID never serves another ID.
- R3: An initiate that matches an outstanding miss is accepted with `req_from_buf_o`=1, increments that miss's waiter count and raises no memory read. This also holds when the miss list is full.
- R4: An initiate that matches no outstanding miss, but matches a ready entry while the miss list has a free slot, is accepted with `req_from_buf_o`=1 and raises no read. It adds one waiter to that entry.
- R5: When all DEPTH miss slots are in use, an initiate that matches no outstanding miss is refused: `req_ack_o`=0 and `mem_rd_valid_o`=0, even if the block is in the ready buffer.
- R6: An initiate that misses everywhere, with a free miss slot, raises `mem_rd_valid_o` with `mem_rd_addr_o` equal to the block-aligned address and `mem_rd_asid_o` equal to the request ID. It is accepted (`req_from_buf_o`=0, one waiter) only when `mem_rd_ready_i` is 1 in that cycle. Otherwise nothing is allocated.
- R7: A fill whose ID and block address match an outstanding miss stores the whole block into that miss. A fill that matches no outstanding miss has no effect.
- R8: A miss completion (`req_from_buf_i`=0) stalls until its block has been filled. It is then accepted, returns the word, removes the entry from the miss list and places it at the most recently used end of the ready buffer, with one waiter fewer.
- R9: When a miss completes while the ready buffer holds DEPTH entries, the lowest-index (least recently used) entry with zero waiters is evicted. If every entry has waiters, the completion stalls and may be retried.
- R10: A buffered completion (`req_from_buf_i`=1) that finds its block in the ready buffer is accepted, returns the word, removes one waiter and moves the entry to the most recently used end. If the block is not in the ready buffer, it stalls.
- R11: The returned word is word number pc[log2(BLK_BYTES)-1:log2(INSN_W/8)] of the block, with word 0 in the least significant bits of the fill data.
- R12: A squash removes one waiter from a matching ready entry and one from a matching outstanding miss. A miss whose count reaches zero is freed: its later fill is ignored, and a new initiate for that block issues a fresh read.
- R13: While `mem_blocked_i` is 1, an initiate is refused with no memory read and no change of state. In particular, no waiter is added to a matching miss.
- R14: A fill and a miss completion for the same block in the same cycle are served in that cycle (the fill is applied first).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid_i | input | 1 | fetch request present |
| req_cmd_i | input | 1 | 0 = initiate, 1 = complete |
| req_from_buf_i | input | 1 | for a completion: 1 = buffered completion, 0 = miss completion |
| req_asid_i | input | ASID_W | address-space ID of the request |
| req_pc_i | input | ADDR_W | fetch address |
| req_ack_o | output | 1 | request accepted or completed this cycle |
| req_from_buf_o | output | 1 | on an accepted initiate: the completion must be a buffered one |
| req_insn_o | output | INSN_W | instruction word on an accepted completion |
| mem_blocked_i | input | 1 | memory port cannot take requests |
| mem_rd_valid_o | output | 1 | block read request |
| mem_rd_ready_i | input | 1 | memory accepts the read this cycle |
| mem_rd_addr_o | output | ADDR_W | block-aligned read address |
| mem_rd_asid_o | output | ASID_W | ID that travels with the read |
| fill_valid_i | input | 1 | fill data present |
| fill_asid_i | input | ASID_W | ID of the fill |
| fill_addr_i | input | ADDR_W | block address of the fill |
| fill_data_i | input | BLK_BYTES*8 | whole block, word 0 in the low bits |
| squash_valid_i | input | 1 | squash one waiter |
| squash_asid_i | input | ASID_W | ID of the squashed request |
| squash_pc_i | input | ADDR_W | fetch address of the squashed request |

## Verification
Two operations that can meet in one cycle are a fill and the completion that waits for it. The bench drives both on the same clock edge for the same block. It judges the result by the acknowledgement and the returned word in that cycle, against a word computed arithmetically from the address and ID. The bench also sweeps every word offset of one block. It drives the ready buffer to full with chosen waiter counts and then predicts, from those counts, which entry is evicted or whether the completion stalls. Finally it fills the miss list to show that refused and blocked initiates leave the waiter counts untouched.

// File: rtl/fetch_blk_buf.sv
module fetch_blk_buf #(
  parameter int DEPTH     = 4,
  parameter int BLK_BYTES = 32,
  parameter int INSN_W    = 32,
  parameter int ASID_W    = 8,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid_i,
  input  logic                   req_cmd_i,
  input  logic                   req_from_buf_i,
  input  logic [ASID_W-1:0]      req_asid_i,
  input  logic [ADDR_W-1:0]      req_pc_i,
  output logic                   req_ack_o,
  output logic                   req_from_buf_o,
  output logic [INSN_W-1:0]      req_insn_o,
  input  logic                   mem_blocked_i,
  output logic                   mem_rd_valid_o,
  input  logic                   mem_rd_ready_i,
  output logic [ADDR_W-1:0]      mem_rd_addr_o,
  output logic [ASID_W-1:0]      mem_rd_asid_o,
  input  logic                   fill_valid_i,
  input  logic [ASID_W-1:0]      fill_asid_i,
  input  logic [ADDR_W-1:0]      fill_addr_i,
  input  logic [BLK_BYTES*8-1:0] fill_data_i,
  input  logic                   squash_valid_i,
  input  logic [ASID_W-1:0]      squash_asid_i,
  input  logic [ADDR_W-1:0]      squash_pc_i
);
  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int SH    = $clog2(INSN_W / 8);
  localparam int WORDS = BLK_BYTES * 8 / INSN_W;
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int OCC_W = $clog2(DEPTH + 1);

  typedef logic [WORDS-1:0][INSN_W-1:0] blk_t;

  logic [DEPTH-1:0] pv, pf, pv_d, pf_d;
  logic [ASID_W-1:0] pasid [DEPTH], pasid_d [DEPTH];
  logic [TAG_W-1:0]  ptag  [DEPTH], ptag_d  [DEPTH];
  logic [CNT_W-1:0]  pcnt  [DEPTH], pcnt_d  [DEPTH];
  blk_t              pdat  [DEPTH], pdat_d  [DEPTH];

  logic [OCC_W-1:0]  rn, rn_d;
  logic [ASID_W-1:0] rasid [DEPTH], rasid_d [DEPTH];
  logic [TAG_W-1:0]  rtag  [DEPTH], rtag_d  [DEPTH];
  logic [CNT_W-1:0]  rcnt  [DEPTH], rcnt_d  [DEPTH];
  blk_t              rdat  [DEPTH], rdat_d  [DEPTH];

  wire [TAG_W-1:0] req_tag = req_pc_i[ADDR_W-1:OFF_W];
  wire [TAG_W-1:0] fil_tag = fill_addr_i[ADDR_W-1:OFF_W];
  wire [TAG_W-1:0] sq_tag  = squash_pc_i[ADDR_W-1:OFF_W];
  wire [WORDS > 1 ? $clog2(WORDS)-1 : 0:0] widx = req_pc_i[OFF_W-1:SH];

  assign mem_rd_addr_o = {req_tag, {OFF_W{1'b0}}};
  assign mem_rd_asid_o = req_asid_i;

  always_comb begin
    int  n, p_idx, r_idx, f_idx, v_idx;
    logic p_hit, r_hit, f_ok, v_ok;
    logic [ASID_W-1:0] m_asid;
    logic [TAG_W-1:0]  m_tag;
    logic [CNT_W-1:0]  m_cnt;
    blk_t              m_dat;
    pv_d = pv; pf_d = pf; rn_d = rn;
    pasid_d = pasid; ptag_d = ptag; pcnt_d = pcnt; pdat_d = pdat;
    rasid_d = rasid; rtag_d = rtag; rcnt_d = rcnt; rdat_d = rdat;
    req_ack_o = 1'b0; req_from_buf_o = 1'b0; req_insn_o = '0;
    mem_rd_valid_o = 1'b0;
    n = int'(rn);
    p_hit = 1'b0; r_hit = 1'b0; f_ok = 1'b0; v_ok = 1'b0;
    p_idx = 0; r_idx = 0; f_idx = 0; v_idx = 0;
    m_asid = '0; m_tag = '0; m_cnt = '0; m_dat = '0;

    for (int i = 0; i < DEPTH; i++)
      if (fill_valid_i && pv[i] && pasid[i] == fill_asid_i && ptag[i] == fil_tag) begin
        pf_d[i] = 1'b1;
        pdat_d[i] = fill_data_i;
      end

    for (int i = 0; i < DEPTH; i++) begin
      if (!p_hit && pv[i] && pasid[i] == req_asid_i && ptag[i] == req_tag) begin
        p_hit = 1'b1; p_idx = i;
      end
      if (!r_hit && i < n && rasid[i] == req_asid_i && rtag[i] == req_tag) begin
        r_hit = 1'b1; r_idx = i;
      end
      if (!f_ok && !pv[i]) begin
        f_ok = 1'b1; f_idx = i;
      end
      if (!v_ok && i < n && rcnt[i] == '0) begin
        v_ok = 1'b1; v_idx = i;
      end
    end

    if (req_valid_i && !req_cmd_i && !mem_blocked_i) begin
      if (p_hit) begin
        pcnt_d[p_idx] = pcnt[p_idx] + 1'b1;
        req_ack_o = 1'b1; req_from_buf_o = 1'b1;
      end else if (f_ok) begin
        if (r_hit) begin
          rcnt_d[r_idx] = rcnt[r_idx] + 1'b1;
          req_ack_o = 1'b1; req_from_buf_o = 1'b1;
        end else begin
          mem_rd_valid_o = 1'b1;
          if (mem_rd_ready_i) begin
            pv_d[f_idx] = 1'b1; pf_d[f_idx] = 1'b0;
            pasid_d[f_idx] = req_asid_i; ptag_d[f_idx] = req_tag;
            pcnt_d[f_idx] = CNT_W'(1);
            req_ack_o = 1'b1;
          end
        end
      end
    end

    if (req_valid_i && req_cmd_i) begin
      if (req_from_buf_i && r_hit) begin
        req_ack_o = 1'b1;
        req_insn_o = rdat[r_idx][widx];
        m_asid = rasid[r_idx]; m_tag = rtag[r_idx]; m_dat = rdat[r_idx];
        m_cnt = (rcnt[r_idx] != '0) ? rcnt[r_idx] - 1'b1 : '0;
        for (int i = 0; i < DEPTH - 1; i++)
          if (i >= r_idx) begin
            rasid_d[i] = rasid_d[i+1]; rtag_d[i] = rtag_d[i+1];
            rcnt_d[i] = rcnt_d[i+1];   rdat_d[i] = rdat_d[i+1];
          end
        n = n - 1;
      end else if (!req_from_buf_i && p_hit && pf_d[p_idx] && (n < DEPTH || v_ok)) begin
        req_ack_o = 1'b1;
        req_insn_o = pdat_d[p_idx][widx];
        m_asid = pasid[p_idx]; m_tag = ptag[p_idx]; m_dat = pdat_d[p_idx];
        m_cnt = (pcnt_d[p_idx] != '0) ? pcnt_d[p_idx] - 1'b1 : '0;
        pv_d[p_idx] = 1'b0; pf_d[p_idx] = 1'b0;
        if (n >= DEPTH) begin
          for (int i = 0; i < DEPTH - 1; i++)
            if (i >= v_idx) begin
              rasid_d[i] = rasid_d[i+1]; rtag_d[i] = rtag_d[i+1];
              rcnt_d[i] = rcnt_d[i+1];   rdat_d[i] = rdat_d[i+1];
            end
          n = n - 1;
        end
      end
      if (req_ack_o) begin
        rasid_d[n] = m_asid; rtag_d[n] = m_tag;
        rcnt_d[n] = m_cnt;   rdat_d[n] = m_dat;
        n = n + 1;
      end
    end

    if (squash_valid_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i < n && rasid_d[i] == squash_asid_i && rtag_d[i] == sq_tag && rcnt_d[i] != '0)
          rcnt_d[i] = rcnt_d[i] - 1'b1;
        if (pv_d[i] && pasid_d[i] == squash_asid_i && ptag_d[i] == sq_tag && pcnt_d[i] != '0) begin
          pcnt_d[i] = pcnt_d[i] - 1'b1;
          if (pcnt_d[i] == '0) begin
            pv_d[i] = 1'b0; pf_d[i] = 1'b0;
          end
        end
      end
    end
    rn_d = OCC_W'(n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0; pf <= '0; rn <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        pcnt[i] <= '0; rcnt[i] <= '0;
        pasid[i] <= '0; ptag[i] <= '0; rasid[i] <= '0; rtag[i] <= '0;
        pdat[i] <= '0; rdat[i] <= '0;
      end
    end else begin
      pv <= pv_d; pf <= pf_d; rn <= rn_d;
      pasid <= pasid_d; ptag <= ptag_d; pcnt <= pcnt_d; pdat <= pdat_d;
      rasid <= rasid_d; rtag <= rtag_d; rcnt <= rcnt_d; rdat <= rdat_d;
    end
  end
endmodule

// File: rtl/fetch_blk_buf_chk.sv
module fetch_blk_buf_chk #(
  parameter int DEPTH = 4,
  parameter int OCC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid_i,
  input logic             req_cmd_i,
  input logic             req_ack_o,
  input logic             mem_blocked_i,
  input logic             mem_rd_valid_o,
  input logic             mem_rd_ready_i,
  input logic             fill_valid_i,
  input logic             squash_valid_i,
  input logic [DEPTH-1:0] pv,
  input logic [OCC_W-1:0] rn
);
  // R13
  blocked_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_blocked_i |-> !mem_rd_valid_o && !(req_valid_i && !req_cmd_i && req_ack_o));

  // R13
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_cmd_i && mem_blocked_i && !fill_valid_i && !squash_valid_i)
      |=> $stable(pv) && $stable(rn));

  // R5
  pend_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&pv) |-> !mem_rd_valid_o);

  // R6
  rd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid_o && !mem_rd_ready_i) |-> !req_ack_o);

  // R6
  rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid_o |-> (req_valid_i && !req_cmd_i));

  // R9
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rn) <= DEPTH);
endmodule

bind fetch_blk_buf fetch_blk_buf_chk #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_cmd_i(req_cmd_i),
  .req_ack_o(req_ack_o), .mem_blocked_i(mem_blocked_i), .mem_rd_valid_o(mem_rd_valid_o),
  .mem_rd_ready_i(mem_rd_ready_i), .fill_valid_i(fill_valid_i),
  .squash_valid_i(squash_valid_i), .pv(pv), .rn(rn));

// File: tb/tb_fetch_blk_buf.sv
module tb_fetch_blk_buf;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid_i = 0, req_cmd_i = 0, req_from_buf_i = 0;
  logic [7:0] req_asid_i = 0;
  logic [31:0] req_pc_i = 0;
  logic req_ack_o, req_from_buf_o;
  logic [31:0] req_insn_o;
  logic mem_blocked_i = 0, mem_rd_valid_o, mem_rd_ready_i = 0;
  logic [31:0] mem_rd_addr_o;
  logic [7:0] mem_rd_asid_o;
  logic fill_valid_i = 0;
  logic [7:0] fill_asid_i = 0;
  logic [31:0] fill_addr_i = 0;
  logic [255:0] fill_data_i = 0;
  logic squash_valid_i = 0;
  logic [7:0] squash_asid_i = 0;
  logic [31:0] squash_pc_i = 0;

  int checks = 0, fails = 0;
  logic o_ack, o_buf, o_rdv;
  logic [31:0] o_insn, o_addr;

  fetch_blk_buf dut (.*);

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] exp_w(input logic [7:0] a, input logic [31:0] pc);
    return {pc[31:2], 2'b00} ^ {a, 24'h0};
  endfunction

  function automatic logic [255:0] mk_blk(input logic [7:0] a, input logic [31:0] blk);
    logic [255:0] d;
    for (int w = 0; w < 8; w++) d[w*32 +: 32] = exp_w(a, {blk[31:5], 5'b0} | 32'(w * 4));
    return d;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic op(input logic cmd, input logic fb, input logic [7:0] a,
                    input logic [31:0] pc, input logic rdy, input logic blk);
    @(negedge clk);
    req_valid_i = 1; req_cmd_i = cmd; req_from_buf_i = fb; req_asid_i = a; req_pc_i = pc;
    mem_rd_ready_i = rdy; mem_blocked_i = blk;
    #1;
    o_ack = req_ack_o; o_buf = req_from_buf_o; o_rdv = mem_rd_valid_o;
    o_insn = req_insn_o; o_addr = mem_rd_addr_o;
    @(posedge clk); #1;
    req_valid_i = 0; mem_rd_ready_i = 0; mem_blocked_i = 0; fill_valid_i = 0; squash_valid_i = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    fill_valid_i = 0; squash_valid_i = 0;
  endtask

  task automatic arm_fill(input logic [7:0] a, input logic [31:0] blk);
    fill_valid_i = 1; fill_asid_i = a; fill_addr_i = blk; fill_data_i = mk_blk(a, blk);
  endtask

  task automatic arm_squash(input logic [7:0] a, input logic [31:0] pc);
    squash_valid_i = 1; squash_asid_i = a; squash_pc_i = pc;
  endtask

  task automatic load(input logic [31:0] blk);
    op(0, 0, 1, blk, 1, 0);
    chk("R6 load ack", {31'b0, o_ack}, 1);
    arm_fill(1, blk); tick();
    op(1, 0, 1, blk + 4, 0, 0);
    chk("R8 load complete", {31'b0, o_ack}, 1);
    chk("R11 load word", o_insn, exp_w(1, blk + 4));
  endtask

  localparam logic [31:0] A = 32'h1000_0000;
  localparam logic [31:0] C = 32'h1000_0100, D = 32'h1000_0200, E = 32'h1000_0300;
  localparam logic [31:0] F = 32'h1000_0400, G = 32'h1000_0500;

  initial begin
    #(CLK_P * 100000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    op(1, 1, 1, A, 0, 0);
    chk("R1 empty completion stalls", {31'b0, o_ack}, 0);
    op(0, 0, 1, A + 32'h14, 0, 0);
    chk("R1 empty initiate reads", {31'b0, o_rdv}, 1);
    chk("R6 not ready no ack", {31'b0, o_ack}, 0);
    chk("R6 aligned read addr", o_addr, A);

    op(0, 0, 1, A + 32'h14, 1, 0);
    chk("R6 miss accepted", {30'b0, o_ack, o_buf}, 2'b10);
    op(1, 0, 1, A + 32'h14, 0, 0);
    chk("R8 unfilled stalls", {31'b0, o_ack}, 0);
    op(0, 0, 1, A + 8, 1, 0);
    chk("R3 merge", {29'b0, o_ack, o_buf, o_rdv}, 3'b110);
    op(0, 0, 2, A + 8, 1, 0);
    chk("R2 other id misses", {29'b0, o_ack, o_buf, o_rdv}, 3'b101);

    arm_fill(1, 32'h2000_0000); tick();
    op(1, 0, 1, A + 32'h14, 0, 0);
    chk("R7 foreign fill ignored", {31'b0, o_ack}, 0);

    arm_fill(1, A);
    op(1, 0, 1, A + 32'h14, 0, 0);
    chk("R14 fill and completion same cycle", {31'b0, o_ack}, 1);
    chk("R8 miss word", o_insn, exp_w(1, A + 32'h14));
    op(1, 1, 1, A + 8, 0, 0);
    chk("R10 buffered completion", {31'b0, o_ack}, 1);
    chk("R11 buffered word", o_insn, exp_w(1, A + 8));
    op(1, 1, 2, A + 8, 0, 0);
    chk("R2 id mismatch stalls", {31'b0, o_ack}, 0);

    arm_squash(2, A + 8); tick();
    arm_fill(2, A); tick();
    op(0, 0, 2, A, 0, 0);
    chk("R12 freed miss reissues read", {30'b0, o_ack, o_rdv}, 2'b01);

    for (int w = 0; w < 8; w++) begin
      op(0, 0, 1, A + 32'(w * 4), 1, 0);
      chk("R4 ready hit", {29'b0, o_ack, o_buf, o_rdv}, 3'b110);
      op(1, 1, 1, A + 32'(w * 4), 0, 0);
      chk("R11 word sweep", o_insn, exp_w(1, A + 32'(w * 4)));
    end

    load(C); load(D); load(E);
    op(0, 0, 1, A, 1, 0);
    chk("R4 pin A", {31'b0, o_buf}, 1);
    load(F);
    op(0, 0, 1, C, 0, 0);
    chk("R9 oldest idle evicted", {30'b0, o_ack, o_rdv}, 2'b01);
    op(0, 0, 1, D, 1, 0);
    chk("R9 D kept", {29'b0, o_ack, o_buf, o_rdv}, 3'b110);
    op(1, 1, 1, D, 0, 0);
    chk("R10 D complete", o_insn, exp_w(1, D));
    op(0, 0, 1, D, 1, 0); op(0, 0, 1, E, 1, 0); op(0, 0, 1, F, 1, 0);
    chk("R4 F pinned", {31'b0, o_buf}, 1);
    op(0, 0, 1, G, 1, 0);
    chk("R6 G read", {30'b0, o_ack, o_rdv}, 2'b11);
    arm_fill(1, G); tick();
    op(1, 0, 1, G, 0, 0);
    chk("R9 all pinned stalls", {31'b0, o_ack}, 0);
    op(1, 1, 1, E + 12, 0, 0);
    chk("R10 E release", o_insn, exp_w(1, E + 12));
    op(1, 0, 1, G + 28, 0, 0);
    chk("R9 retry succeeds", {31'b0, o_ack}, 1);
    chk("R11 G word", o_insn, exp_w(1, G + 28));
    op(0, 0, 1, E, 0, 0);
    chk("R9 E evicted", {30'b0, o_ack, o_rdv}, 2'b01);

    for (int k = 0; k < 4; k++) begin
      op(0, 0, 1, 32'h2000_0000 + 32'(k * 256), 1, 0);
      chk("R6 fill miss list", {31'b0, o_ack}, 1);
    end
    op(0, 0, 1, 32'h2000_0400, 1, 0);
    chk("R5 full list refuses miss", {30'b0, o_ack, o_rdv}, 2'b00);
    op(0, 0, 1, A, 1, 0);
    chk("R5 full list refuses ready hit", {30'b0, o_ack, o_rdv}, 2'b00);
    op(0, 0, 1, 32'h2000_0000, 1, 0);
    chk("R3 merge with full list", {29'b0, o_ack, o_buf, o_rdv}, 3'b110);

    op(0, 0, 1, 32'h2000_0100, 1, 1);
    chk("R13 blocked refused", {30'b0, o_ack, o_rdv}, 2'b00);
    arm_squash(1, 32'h2000_0100); tick();
    op(0, 0, 1, 32'h2000_0100, 0, 0);
    chk("R13 blocked added no waiter", {30'b0, o_ack, o_rdv}, 2'b01);
    op(0, 0, 1, 32'h3000_0000, 1, 1);
    chk("R13 blocked miss no read", {30'b0, o_ack, o_rdv}, 2'b00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule